// File: doc/BRIEF.md
# ROM/SRAM Decode and Wait-State Controller

This block sits between a 32-bit processor bus and an external memory built from byte-wide ROM and SRAM devices. It looks at each request the processor presents and routes it by the top address bit: high goes to ROM, low goes to SRAM. It then drives the matching output enable, or one write strobe per byte lane of the SRAM. For slow ROM it holds the processor in wait states, so each ROM access lasts a fixed number of cycles.

A request has two hint inputs. The request flag marks a memory cycle. The sequential flag marks an access that follows on from the previous one. A non-sequential request costs one extra decode cycle, and the processor is stalled during that cycle. A sequential request skips the decode cycle and starts its access on the next clock. SRAM accesses never stall. When the request flag drops, the controller returns to idle.

All outputs are decoded from flip-flops only, so no input-to-output path passes through the block. The processor must hold its inputs while `stall` is high. The controller accepts a request at the clock edge that closes a cycle in which `stall` was low and the controller was not in a decode cycle.

Top module: `memwait_ctrl`

## Requirements
- R1: After synchronous reset, `ram_rd_en`, `rom_rd_en`, `stall` and every bit of `ram_wr_lane` are low.
- R2: An accepted request with `addr_msb`=1 takes the ROM path. One with `addr_msb`=0 takes the SRAM path.
- R3: An accepted request with `seq`=0 first spends exactly one cycle in decode. In that cycle `stall` is high and no enable is driven. The access starts in the cycle after.
- R4: An accepted request with `seq`=1 starts its access in the cycle right after the accepting edge, with no decode cycle.
- R5: A ROM access lasts ROM_WAITS+1 cycles (3 by default). `stall` is high in all but the last of them. For a read, `rom_rd_en` is high in all of them.
- R6: An SRAM access lasts one cycle with `stall` low. Back-to-back sequential SRAM requests are accepted on consecutive edges.
- R7: Bit i of `ram_wr_lane` strobes data bits [8i+7:8i]. A byte write (`xfer_size`=00) asserts only the bit given by `addr_lo`.
- R8: A halfword write (`xfer_size`=01) asserts bits 3 and 2 when `addr_lo[1]`=1, and bits 1 and 0 otherwise. `addr_lo[0]` has no effect.
- R9: A word write (`xfer_size`=10) asserts all four bits for any `addr_lo`. Size code 11 asserts none.
- R10: An SRAM read (`wr`=0) asserts `ram_rd_en` and no write bit. A ROM write asserts no enable at all but keeps the ROM timing of R5.
- R11: When `req` is low at an edge, the next cycle is idle: no enable and `stall` low. This holds even in the middle of a ROM access.
- R12: While `stall` is high, changes on `addr_msb`, `addr_lo`, `wr` and `xfer_size` have no effect. The access uses the values captured when it was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| addr_msb | input | 1 | Top address bit: 1 = ROM, 0 = SRAM |
| addr_lo | input | 2 | Byte offset within the 32-bit word |
| wr | input | 1 | 1 = write, 0 = read |
| xfer_size | input | 2 | 00 byte, 01 halfword, 10 word, 11 reserved |
| req | input | 1 | Memory request for this cycle |
| seq | input | 1 | Request follows on from the previous access |
| ram_rd_en | output | 1 | SRAM output enable |
| rom_rd_en | output | 1 | ROM output enable |
| ram_wr_lane | output | 4 | Per-byte-lane SRAM write strobes |
| stall | output | 1 | Wait request to the processor |

## Verification
Suppose the controller sits in the wrong state, or its ROM wait chain counts wrongly. That shows at the ports within one cycle of the faulty edge. `stall` rises or falls a cycle early or late, or a ROM enable stays on when an SRAM enable should be on. Bad captured attributes show on the first access cycle as the wrong lane pattern or a read enable in place of a write strobe. The bench keeps a cycle-accurate reference of phase and wait count. It compares all four outputs every cycle, over random traffic that also scrambles the held inputs during stalls and drops the request in the middle of accesses.

// File: rtl/memwait_pkg.sv
package memwait_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } xfer_size_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_DECODE = 2'd1,
    ST_RAM    = 2'd2,
    ST_ROM    = 2'd3
  } mem_state_e;

endpackage

// File: rtl/memwait_lanes.sv
module memwait_lanes
  import memwait_pkg::*;
#(
  parameter int LANES = 4,
  localparam int LO_W = $clog2(LANES)
) (
  input  logic             en,
  input  logic [1:0]       size,
  input  logic [LO_W-1:0]  lo,
  output logic [LANES-1:0] lane
);

  xfer_size_e sz;
  assign sz = xfer_size_e'(size);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam logic [LO_W-1:0] IDX = LO_W'(i);
    logic hit;
    always_comb begin
      case (sz)
        SZ_BYTE: hit = (lo == IDX);
        SZ_HALF: hit = (lo[LO_W-1:1] == IDX[LO_W-1:1]);
        SZ_WORD: hit = 1'b1;
        default: hit = 1'b0;
      endcase
    end
    assign lane[i] = en && hit;
  end

endmodule

// File: rtl/memwait_romchain.sv
module memwait_romchain #(
  parameter int WAITS = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic load,
  input  logic adv,
  output logic last
);

  logic [WAITS:0] chain;

  always_ff @(posedge clk) begin
    if (rst || clr)  chain <= '0;
    else if (load)   chain <= (WAITS+1)'(1);
    else if (adv)    chain <= {chain[WAITS-1:0], 1'b0};
  end

  assign last = chain[WAITS];

  // R5: the wait token is never duplicated
  assert_chain_onehot_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(chain));

endmodule

// File: rtl/memwait_fsm.sv
module memwait_fsm
  import memwait_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       req,
  input  logic       seq,
  input  logic       addr_msb,
  input  logic       cap_rom,
  input  logic       rom_last,
  output mem_state_e state,
  output logic       accept,
  output logic       rom_load,
  output logic       rom_adv,
  output logic       rom_clr
);

  mem_state_e nxt;
  logic       rom_busy;

  always_comb begin
    rom_busy = (state == ST_ROM) && !rom_last;
    accept   = (state == ST_IDLE) || (state == ST_RAM) ||
               ((state == ST_ROM) && rom_last);
    if (!req)                    nxt = ST_IDLE;
    else if (state == ST_DECODE) nxt = cap_rom ? ST_ROM : ST_RAM;
    else if (rom_busy)           nxt = ST_ROM;
    else if (seq)                nxt = addr_msb ? ST_ROM : ST_RAM;
    else                         nxt = ST_DECODE;
    rom_load = req && (nxt == ST_ROM) && !rom_busy;
    rom_adv  = req && rom_busy;
    rom_clr  = !req || (nxt != ST_ROM);
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= nxt;
  end

  // R3: decode never lasts more than one cycle
  assert_decode_once_R3: assert property (@(posedge clk) disable iff (rst)
    (req && state == ST_DECODE) |=> (state == ST_ROM || state == ST_RAM));

endmodule

// File: rtl/memwait_ctrl.sv
module memwait_ctrl
  import memwait_pkg::*;
#(
  parameter int LANES     = 4,
  parameter int ROM_WAITS = 2,
  localparam int LO_W     = $clog2(LANES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             addr_msb,
  input  logic [LO_W-1:0]  addr_lo,
  input  logic             wr,
  input  logic [1:0]       xfer_size,
  input  logic             req,
  input  logic             seq,
  output logic             ram_rd_en,
  output logic             rom_rd_en,
  output logic [LANES-1:0] ram_wr_lane,
  output logic             stall
);

  mem_state_e      state;
  logic            accept, rom_last, rom_load, rom_adv, rom_clr;
  logic            cap_rom, cap_wr;
  logic [1:0]      cap_size;
  logic [LO_W-1:0] cap_lo;

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_rom  <= 1'b0;
      cap_wr   <= 1'b0;
      cap_size <= '0;
      cap_lo   <= '0;
    end else if (accept && req) begin
      cap_rom  <= addr_msb;
      cap_wr   <= wr;
      cap_size <= xfer_size;
      cap_lo   <= addr_lo;
    end
  end

  memwait_fsm i_fsm (
    .clk      (clk),
    .rst      (rst),
    .req      (req),
    .seq      (seq),
    .addr_msb (addr_msb),
    .cap_rom  (cap_rom),
    .rom_last (rom_last),
    .state    (state),
    .accept   (accept),
    .rom_load (rom_load),
    .rom_adv  (rom_adv),
    .rom_clr  (rom_clr)
  );

  memwait_romchain #(.WAITS(ROM_WAITS)) i_chain (
    .clk  (clk),
    .rst  (rst),
    .clr  (rom_clr),
    .load (rom_load),
    .adv  (rom_adv),
    .last (rom_last)
  );

  memwait_lanes #(.LANES(LANES)) i_lanes (
    .en   ((state == ST_RAM) && cap_wr),
    .size (cap_size),
    .lo   (cap_lo),
    .lane (ram_wr_lane)
  );

  assign ram_rd_en = (state == ST_RAM) && !cap_wr;
  assign rom_rd_en = (state == ST_ROM) && !cap_wr;
  assign stall     = (state == ST_DECODE) || ((state == ST_ROM) && !rom_last);

  // R5: a ROM access in its wait cycles stays on the ROM path
  assert_rom_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (req && state == ST_ROM && stall) |=> (state == ST_ROM));

  // R11: a dropped request leaves the next cycle idle
  assert_idle_drop_R11: assert property (@(posedge clk) disable iff (rst)
    !req |=> (!stall && !ram_rd_en && !rom_rd_en && ram_wr_lane == '0));

  // R12: captured attributes are frozen while stalled
  assert_caps_held_R12: assert property (@(posedge clk) disable iff (rst)
    (req && stall) |=> ($stable(cap_rom) && $stable(cap_wr) &&
                        $stable(cap_size) && $stable(cap_lo)));

  // R10: at most one kind of enable per cycle
  assert_one_enable_R10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ram_rd_en, rom_rd_en, |ram_wr_lane}));

  // R8: lane patterns are a single lane, a pair or all of them
  assert_lane_shape_R8: assert property (@(posedge clk) disable iff (rst)
    (ram_wr_lane != '0) |-> ($countones(ram_wr_lane) == 1 ||
      $countones(ram_wr_lane) == 2 || $countones(ram_wr_lane) == LANES));

endmodule

// File: tb/test_memwait_ctrl.sv
`timescale 1ns/1ps
module test_memwait_ctrl;

  localparam int WAITS = 2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       addr_msb = 1'b0, wr = 1'b0, req = 1'b0, seq = 1'b0;
  logic [1:0] addr_lo = '0, xfer_size = '0;
  logic       ram_rd_en, rom_rd_en, stall;
  logic [3:0] ram_wr_lane;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // reference model: 0 idle, 1 decode, 2 ram, 3 rom
  int       m_ph = 0;
  int       m_cnt = 0;
  bit       m_rom = 0, m_wr = 0;
  bit [1:0] m_size = 0, m_lo = 0;

  always #2 clk = ~clk;

  memwait_ctrl i_memwait_ctrl (
    .clk, .rst, .addr_msb, .addr_lo, .wr, .xfer_size, .req, .seq,
    .ram_rd_en, .rom_rd_en, .ram_wr_lane, .stall
  );

  function automatic logic [3:0] exp_mask(bit [1:0] s, bit [1:0] o);
    case (s)
      2'b00:   return 4'b0001 << o;
      2'b01:   return o[1] ? 4'b1100 : 4'b0011;
      2'b10:   return 4'b1111;
      default: return 4'b0000;
    endcase
  endfunction

  function automatic bit exp_stall();
    return (m_ph == 1) || (m_ph == 3 && m_cnt < WAITS);
  endfunction

  task automatic model_step();
    if (!req) m_ph = 0;
    else if (m_ph == 1) begin m_ph = m_rom ? 3 : 2; m_cnt = 0; end
    else if (m_ph == 3 && m_cnt < WAITS) m_cnt++;
    else begin
      m_rom = addr_msb; m_wr = wr; m_size = xfer_size; m_lo = addr_lo;
      m_ph = seq ? (addr_msb ? 3 : 2) : 1;
      m_cnt = 0;
    end
  endtask

  task automatic chk(string tag, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic compare(string tag);
    chk(tag, "stall", int'(stall), int'(exp_stall()));
    chk(tag, "rom_rd_en", int'(rom_rd_en), int'(m_ph == 3 && !m_wr));
    chk(tag, "ram_rd_en", int'(ram_rd_en), int'(m_ph == 2 && !m_wr));
    chk(tag, "ram_wr_lane", int'(ram_wr_lane),
        (m_ph == 2 && m_wr) ? int'(exp_mask(m_size, m_lo)) : 0);
  endtask

  // drive after a falling edge, step at the rising edge, sample at the next falling edge
  task automatic cyc(bit r, bit s, bit ms, bit w, bit [1:0] sz, bit [1:0] lo, string tag);
    req = r; seq = s; addr_msb = ms; wr = w; xfer_size = sz; addr_lo = lo;
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare(tag);
  endtask

  task automatic hold(int n, string tag);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      model_step();
      @(negedge clk);
      compare(tag);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1c0ffee));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1", "stall", int'(stall), 0);
    chk("R1", "rom_rd_en", int'(rom_rd_en), 0);
    chk("R1", "ram_rd_en", int'(ram_rd_en), 0);
    chk("R1", "ram_wr_lane", int'(ram_wr_lane), 0);

    // R3 non-sequential ROM read: decode, then R5 three ROM cycles
    cyc(1, 0, 1, 0, 2'b10, 0, "R3");
    hold(3, "R5");
    // R4 sequential SRAM word write directly after ROM
    cyc(1, 1, 0, 1, 2'b10, 0, "R4");
    // R7 byte lanes
    for (int o = 0; o < 4; o++) cyc(1, 1, 0, 1, 2'b00, 2'(o), "R7");
    // R8 halfword lanes
    for (int o = 0; o < 4; o++) cyc(1, 1, 0, 1, 2'b01, 2'(o), "R8");
    // R9 word and reserved size
    cyc(1, 1, 0, 1, 2'b10, 2'd3, "R9");
    cyc(1, 1, 0, 1, 2'b11, 2'd1, "R9");
    // R6 back-to-back sequential SRAM reads, no stall
    for (int k = 0; k < 3; k++) cyc(1, 1, 0, 0, 2'b10, 0, "R6");
    // R10 ROM write: ROM timing, no enables; then SRAM read
    cyc(1, 1, 1, 1, 2'b10, 0, "R10");
    hold(2, "R10");
    cyc(1, 1, 0, 0, 2'b00, 2, "R10");
    // R11 drop request mid-ROM
    cyc(1, 1, 1, 0, 2'b10, 0, "R11");
    cyc(0, 0, 1, 0, 2'b10, 0, "R11");
    // R12 inputs scrambled during decode are ignored
    cyc(1, 0, 0, 1, 2'b10, 0, "R12");
    cyc(1, 0, 1, 0, 2'b00, 3, "R12");
    // R2 random traffic
    for (int n = 0; n < 3000; n++) begin
      if (exp_stall() && ($urandom % 16) != 0) begin
        if (($urandom % 6) == 0)
          cyc(1, seq, 1'($urandom), 1'($urandom), 2'($urandom), 2'($urandom), "R12");
        else
          cyc(1, seq, addr_msb, wr, xfer_size, addr_lo, "R5");
      end else begin
        cyc(($urandom % 8) != 0, 1'($urandom), 1'($urandom), 1'($urandom),
            2'($urandom), 2'($urandom), "R2");
      end
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule